// File: doc/BRIEF.md
# MSK Burst Preamble and Framing Sequencer

This block produces the transmit bit stream of one burst on a burst-mode minimum-shift-keying link. A start request opens the burst. The block first sends a preamble that is exactly one frame long and is built from the bit pattern 1,1,0,0 repeated. It then sends data frames. Each data frame opens with a fixed synchronization word, and the rest of the frame carries payload bits taken from an upstream stream. When the upstream marks its final bit, the current frame is padded out with zeros. A closing end-of-transmission frame follows, so that a receiver can tell a deliberate end from a lost signal. The block then returns to idle.

Bit timing comes from a one-cycle bit-rate enable. Each enable seen during a burst produces exactly one output bit, presented on `tx_bit_o` with a one-cycle `tx_stb_o`. The payload input follows valid/ready rules. `pl_ready_o` is high only in a payload slot, and only in a cycle where `bit_en_i` is high, so at most one bit transfers per bit period. The upstream may hold `pl_valid_i` low at any time; the block never waits for it. If no bit is offered in a payload slot, a zero fill bit is sent and flagged, and the bit timing is unchanged. `pl_data_i` and `pl_last_i` are sampled only in the cycle of a transfer.

With the default parameters a frame is 2168 bit periods, which is 40 ms at 54.2 kbit/s. The sync word is 16 bits and the end frame is one full frame long.

Top module: `msk_burst_framer`

## Requirements
- R1: After reset, `busy_o`, `tx_stb_o`, `tx_bit_o`, `underrun_o` and `pl_ready_o` are all 0.
- R2: A `start_i` pulse while idle sets `busy_o` in the next cycle. A `start_i` pulse during a burst changes nothing in the bit stream.
- R3: During a burst, each cycle with `bit_en_i` high gives exactly one `tx_stb_o` pulse in the following cycle. `tx_bit_o` changes only along with a strobe.
- R4: The first FRAME_BITS bits of a burst form the preamble: the repeating sequence 1,1,0,0, starting with 1.
- R5: Every data frame is FRAME_BITS bits long. Its first SYNC_BITS bits are SYNC_WORD, sent most significant bit first.
- R6: Payload bits fill the remaining FRAME_BITS-SYNC_BITS positions of each data frame in upstream order. `pl_ready_o` is high only in a payload slot and only with `bit_en_i`.
- R7: When `pl_valid_i` is low in a payload slot, the bit sent is 0 and `underrun_o` is high together with that bit's strobe.
- R8: After the transfer that carries `pl_last_i`, `pl_ready_o` stays low. The rest of that frame is 0 bits without `underrun_o`.
- R9: The data frames are followed by one end frame of FRAME_BITS bits. Its bits repeat EOT_PAT, most significant bit first; the default 4'b1010 gives 1,0,1,0.
- R10: `busy_o` falls in the same cycle as the strobe of the final end-frame bit, and no strobe follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst start request |
| bit_en_i | input | 1 | One-cycle bit-rate enable |
| pl_valid_i | input | 1 | Payload bit valid |
| pl_data_i | input | 1 | Payload bit |
| pl_last_i | input | 1 | Marks the final payload bit |
| pl_ready_o | output | 1 | Payload bit accepted in this cycle |
| tx_bit_o | output | 1 | Current output bit |
| tx_stb_o | output | 1 | New output bit strobe |
| busy_o | output | 1 | Burst in progress |
| underrun_o | output | 1 | Current bit is a zero fill |

## Verification
A wrong segment counter or a wrong state shows up at the first strobe after the fault. The fault appears as a preamble phase slip, a sync word at the wrong position, or an end frame that starts early. The bench therefore compares every output bit against a position-based model of the whole burst. A fault in the payload handshake either shifts the order of the upstream bits or leaves a transfer missing. It is seen within one payload bit, and again in the total transfer count at the end of the burst. A fault in burst termination shows up as a wrong total bit count, or as `busy_o` falling at the wrong moment relative to the last strobe.

// File: rtl/msk_frm_pkg.sv
package msk_frm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYNC,
    ST_PAY,
    ST_EOT
  } frm_state_t;
endpackage

// File: rtl/msk_frm_counter.sv
module msk_frm_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] last_idx,
  output logic [W-1:0] idx,
  output logic         at_end
);
  assign at_end = (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx <= '0;
    else if (adv)      idx <= at_end ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/msk_frm_bitsel.sv
module msk_frm_bitsel
  import msk_frm_pkg::*;
#(
  parameter int                   IDX_W     = 12,
  parameter int                   SYNC_BITS = 16,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 16'hE5A3,
  parameter int                   EOT_BITS  = 4,
  parameter logic [EOT_BITS-1:0]  EOT_PAT   = 4'b1010
) (
  input  frm_state_t       state,
  input  logic [IDX_W-1:0] idx,
  input  logic             pay_bit,
  output logic             bit_o
);
  localparam int SW = (SYNC_BITS > 1) ? $clog2(SYNC_BITS) : 1;
  localparam int EW = (EOT_BITS > 1) ? $clog2(EOT_BITS) : 1;

  logic [(1<<SW)-1:0] sync_rev;
  logic [(1<<EW)-1:0] eot_rev;

  // Reverse both patterns so the bit index within the segment selects
  // them most significant bit first; unused tail positions read 0.
  for (genvar g = 0; g < (1<<SW); g++) begin : g_sync
    if (g < SYNC_BITS) begin : g_used
      assign sync_rev[g] = SYNC_WORD[SYNC_BITS-1-g];
    end else begin : g_pad
      assign sync_rev[g] = 1'b0;
    end
  end
  for (genvar g = 0; g < (1<<EW); g++) begin : g_eot
    if (g < EOT_BITS) begin : g_used
      assign eot_rev[g] = EOT_PAT[EOT_BITS-1-g];
    end else begin : g_pad
      assign eot_rev[g] = 1'b0;
    end
  end

  always_comb begin
    case (state)
      ST_PRE:  bit_o = ~idx[1];
      ST_SYNC: bit_o = sync_rev[idx[SW-1:0]];
      ST_PAY:  bit_o = pay_bit;
      ST_EOT:  bit_o = eot_rev[idx[EW-1:0]];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/msk_burst_framer.sv
module msk_burst_framer
  import msk_frm_pkg::*;
#(
  parameter int                   FRAME_BITS = 2168,
  parameter int                   SYNC_BITS  = 16,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD  = 16'hE5A3,
  parameter int                   EOT_BITS   = 4,
  parameter logic [EOT_BITS-1:0]  EOT_PAT    = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_en_i,
  input  logic pl_valid_i,
  input  logic pl_data_i,
  input  logic pl_last_i,
  output logic pl_ready_o,
  output logic tx_bit_o,
  output logic tx_stb_o,
  output logic busy_o,
  output logic underrun_o
);
  localparam int IDX_W    = $clog2(FRAME_BITS);
  localparam int PAY_BITS = FRAME_BITS - SYNC_BITS;

  frm_state_t       state;
  logic             last_seen;
  logic [IDX_W-1:0] idx, seg_last;
  logic             at_end, adv, take, pay_bit, nxt_bit, ends_data;

  always_comb begin
    case (state)
      ST_SYNC: seg_last = IDX_W'(SYNC_BITS - 1);
      ST_PAY:  seg_last = IDX_W'(PAY_BITS - 1);
      ST_PRE,
      ST_EOT:  seg_last = IDX_W'(FRAME_BITS - 1);
      default: seg_last = '0;
    endcase
  end

  assign adv        = bit_en_i && (state != ST_IDLE);
  assign pl_ready_o = (state == ST_PAY) && bit_en_i && !last_seen;
  assign take       = pl_ready_o && pl_valid_i;
  assign pay_bit    = take && pl_data_i;
  assign ends_data  = last_seen || (take && pl_last_i);
  assign busy_o     = (state != ST_IDLE);

  msk_frm_counter #(.W(IDX_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state == ST_IDLE),
    .adv      (adv),
    .last_idx (seg_last),
    .idx      (idx),
    .at_end   (at_end)
  );

  msk_frm_bitsel #(
    .IDX_W     (IDX_W),
    .SYNC_BITS (SYNC_BITS),
    .SYNC_WORD (SYNC_WORD),
    .EOT_BITS  (EOT_BITS),
    .EOT_PAT   (EOT_PAT)
  ) u_sel (
    .state   (state),
    .idx     (idx),
    .pay_bit (pay_bit),
    .bit_o   (nxt_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      last_seen <= 1'b0;
    end else begin
      if (take && pl_last_i) last_seen <= 1'b1;
      case (state)
        ST_IDLE: if (start_i) begin
          state     <= ST_PRE;
          last_seen <= 1'b0;
        end
        ST_PRE:  if (adv && at_end) state <= ST_SYNC;
        ST_SYNC: if (adv && at_end) state <= ST_PAY;
        ST_PAY:  if (adv && at_end) state <= ends_data ? ST_EOT : ST_SYNC;
        ST_EOT:  if (adv && at_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bit_o   <= 1'b0;
      tx_stb_o   <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      tx_stb_o   <= adv;
      underrun_o <= pl_ready_o && !pl_valid_i;
      if (adv) tx_bit_o <= nxt_bit;
    end
  end
endmodule

// File: rtl/msk_burst_framer_chk.sv
module msk_burst_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic bit_en_i,
  input logic pl_ready_o,
  input logic tx_bit_o,
  input logic tx_stb_o,
  input logic busy_o,
  input logic underrun_o
);
  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_stb_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb_o |-> $past(bit_en_i));

  assert_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_stb_o |-> $stable(tx_bit_o));

  assert_ready_paced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready_o |-> (bit_en_i && busy_o));

  assert_fill_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> (tx_stb_o && !tx_bit_o));

  assert_stb_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb_o |-> (busy_o || $past(busy_o)));
endmodule

bind msk_burst_framer msk_burst_framer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .bit_en_i   (bit_en_i),
  .pl_ready_o (pl_ready_o),
  .tx_bit_o   (tx_bit_o),
  .tx_stb_o   (tx_stb_o),
  .busy_o     (busy_o),
  .underrun_o (underrun_o)
);

// File: tb/msk_burst_framer_tb_top.sv
module msk_burst_framer_tb_top;
  localparam int              F  = 2168;
  localparam int              S  = 16;
  localparam logic [S-1:0]    SW = 16'hE5A3;
  localparam logic [3:0]      EP = 4'b1010;
  // {payload bits, bit-enable period, start pulse mid-burst}
  localparam int NV = 4;
  localparam int VEC [NV][3] = '{'{5, 1, 0}, '{2152, 2, 1}, '{2153, 1, 0}, '{1, 3, 0}};

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, bit_en_i = 1'b0;
  logic pl_valid_i = 1'b0, pl_data_i = 1'b0, pl_last_i = 1'b0;
  logic pl_ready_o, tx_bit_o, tx_stb_o, busy_o, underrun_o;

  int n_cmp = 0, n_bad = 0;
  int cur_n = 0, cur_u = 0, period = 1, pos = 0, total = 0, sent = 0, cyc = 0;
  bit mon_on = 1'b0, drv_on = 1'b0;

  always #4 clk = ~clk;

  msk_burst_framer #(.FRAME_BITS(F), .SYNC_BITS(S), .SYNC_WORD(SW),
                     .EOT_BITS(4), .EOT_PAT(EP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_en_i(bit_en_i),
    .pl_valid_i(pl_valid_i), .pl_data_i(pl_data_i), .pl_last_i(pl_last_i),
    .pl_ready_o(pl_ready_o), .tx_bit_o(tx_bit_o), .tx_stb_o(tx_stb_o),
    .busy_o(busy_o), .underrun_o(underrun_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (bit position %0d)", req, act, exp, pos);
    end
  endtask

  function automatic int dbit(int k);
    return ((k % 3) == 0 || (k % 7) == 2) ? 1 : 0;
  endfunction

  function automatic int data_end(int n, int u);
    int fr = (n + u + (F - S) - 1) / (F - S);
    if (fr < 1) fr = 1;
    return F + fr * F;
  endfunction

  // Expected bit, expected fill flag and requirement tag at burst position p
  function automatic int exp_bit(int p, output int und, output string tag);
    int de = data_end(cur_n, cur_u);
    und = 0;
    if (p < F) begin
      tag = "R4"; return ((p % 4) < 2) ? 1 : 0;
    end else if (p < de) begin
      int q = p - F;
      int r = q % F;
      if (r < S) begin tag = "R5"; return int'(SW[S-1-r]); end
      begin
        int j = (q / F) * (F - S) + r - S;
        if (j < cur_u) begin tag = "R7"; und = 1; return 0; end
        if (j - cur_u < cur_n) begin tag = "R6"; return dbit(j - cur_u); end
        tag = "R8"; return 0;
      end
    end
    tag = "R9";
    return int'(EP[3 - ((p - de) % 4)]);
  endfunction

  always @(posedge clk) if (pl_valid_i && pl_ready_o) sent++;

  always @(negedge clk) begin
    if (mon_on) begin
      if (pl_ready_o) chk(bit_en_i, "R6 ready without bit enable", 0, 1);
      if (pl_ready_o) chk(sent < cur_n, "R8 ready after last", sent, cur_n - 1);
      if (tx_stb_o) begin
        int eb, eu;
        string tg;
        chk(bit_en_i, "R3 strobe without enable", 0, 1);
        if (pos >= total) chk(1'b0, "R10 strobe after end frame", pos, total - 1);
        else begin
          eb = exp_bit(pos, eu, tg);
          chk(int'(tx_bit_o) == eb, tg, int'(tx_bit_o), eb);
          chk(int'(underrun_o) == eu, "R7 fill flag", int'(underrun_o), eu);
          chk(busy_o == (pos != total - 1), "R10 busy at strobe", int'(busy_o),
              int'(pos != total - 1));
        end
        pos++;
      end
    end
    cyc++;
    bit_en_i   = drv_on && ((cyc % period) == 0);
    pl_valid_i = drv_on && (sent < cur_n) && (cur_u == 0 || pos >= F + S + cur_u);
    pl_data_i  = dbit(sent) != 0;
    pl_last_i  = (sent == cur_n - 1);
  end

  task automatic run_burst(input int n, input int per, input int u, input bit restart);
    cur_n = n; cur_u = u; period = per; sent = 0; pos = 0;
    total = data_end(n, u) + F;
    mon_on = 1'b1; drv_on = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o, "R2 busy after start", int'(busy_o), 1);
    if (restart) begin
      while (pos < 100) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      chk(busy_o, "R2 start ignored while busy", int'(busy_o), 1);
    end
    while (busy_o) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(pos == total, "R9 bits per burst", pos, total);
    chk(sent == n, "R6 payload transfers", sent, n);
    mon_on = 1'b0; drv_on = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !tx_stb_o && !tx_bit_o && !underrun_o && !pl_ready_o,
        "R1 reset outputs", int'({busy_o, tx_stb_o, tx_bit_o, underrun_o, pl_ready_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !tx_stb_o, "R1 idle after reset", int'(busy_o), 0);
    for (int v = 0; v < NV; v++) run_burst(VEC[v][0], VEC[v][1], 0, VEC[v][2] != 0);
    // Directed: three leading payload slots with no valid bit (R7)
    run_burst(40, 1, 3, 1'b0);
    // Directed: idle with bit enables produces no strobes (R3)
    drv_on = 1'b1; period = 1; cur_n = 0;
    repeat (20) begin
      @(negedge clk);
      chk(!tx_stb_o && !busy_o, "R3 no strobe while idle", int'(tx_stb_o), 0);
    end
    drv_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule